// File: doc/BRIEF.md
# Lock-Switched Phase/Frequency Comparator

This block compares the rising edges of a reference tone and a divided synthesizer tone and turns the difference into two pump-steering pulses. Whichever tone rises first opens its pulse: a leading reference raises `up`, a leading synthesizer tone raises `dn`. When the other tone's edge arrives, both pulses are high for one cycle and then close together. The length of each pulse therefore tracks the phase error, and its polarity shows which tone leads. Both tones are resynchronised to a fast sampling clock, and that clock also measures how long each pulse lasts.

Around the comparator sits a lock supervisor that picks the charge-pump current code. The pump starts in high-current mode and uses `code_hi`. Software can request low current at any time. When automatic detection is enabled, a run of consecutive short error pulses (each below a threshold in sampling-clock cycles) drops the pump to `code_lo` and keeps it there. Only a divider-write strobe brings the pump back to high current. The loop-filter switch output follows high-current mode. All pins are plain control and status levels, and nothing flows through the block under back-pressure.

Top module: `pump_mode_pfd`

## Requirements
- R1: After reset, `up` and `dn` are 0, `hi_mode` and `lpf_hc` are 1, and `cur_code` equals `code_hi`.
- R2: When the synchronised `fref` edge leads the `fsyn` edge by d sampling cycles (d ≥ 1), `up` is high for d+1 cycles and `dn` is high for 1 cycle.
- R3: When the synchronised `fsyn` edge leads the `fref` edge by d sampling cycles (d ≥ 1), `dn` is high for d+1 cycles and `up` is high for 1 cycle.
- R4: Rising edges of `fref` and `fsyn` that reach the comparator in the same cycle make `up` and `dn` each high for exactly one cycle.
- R5: Whenever `up` and `dn` are both 1, both are 0 in the following cycle.
- R6: `cur_code` equals `code_hi` while `hi_mode` is 1 and equals `code_lo` while it is 0.
- R7: While `sw_low` is 1, `hi_mode` is 0.
- R8: With `ld_en` = 1, `hi_mode` drops to 0 after LOCK_CNT (default 3) consecutive error episodes of width below LOCK_THR (default 4) cycles. The width is counted from the opening of the first pulse to the common close, overlap cycle included, so a width equal to LOCK_THR does not count as short.
- R9: An error episode of width at least LOCK_THR restarts the count of consecutive short episodes.
- R10: While `ld_en` is 0, automatic low-current mode is never entered, and clearing `ld_en` returns the pump to high current unless `sw_low` is 1.
- R11: Once locked, the pump stays in low-current mode through long error pulses. A one-cycle `div_wr` returns `hi_mode` to 1 in the next cycle (unless `sw_low` is 1) and restarts the short-episode count.
- R12: `lpf_hc` equals `hi_mode` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fref | input | 1 | Reference tone |
| fsyn | input | 1 | Divided synthesizer tone |
| ld_en | input | 1 | Enables automatic low-current mode on lock |
| sw_low | input | 1 | Software request for low-current mode |
| div_wr | input | 1 | One-cycle strobe marking a divider reprogram |
| code_hi | input | CODE_W | Pump current code for high-current mode |
| code_lo | input | CODE_W | Pump current code for low-current mode |
| up | output | 1 | Pump-up pulse (reference leads) |
| dn | output | 1 | Pump-down pulse (synthesizer leads) |
| cur_code | output | CODE_W | Selected pump current code |
| hi_mode | output | 1 | High-current mode active |
| lpf_hc | output | 1 | Loop-filter high-current switch |

## Verification
The hardest states to reach are those that depend on the history of the lock count: a long episode inside a run of short ones, a divider write in the middle of a run, and a width exactly at the threshold. The stimulus reaches them by placing tone edges on falling clock edges with an exact offset in cycles. This makes the width of every episode a known number, so each run of short and long episodes can be laid out one episode at a time. A scoreboard queue holds the expected `up` and `dn` widths of each episode. Mode checks follow the runs that should lock and the runs that should not.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // Comparator state; bit 0 drives up, bit 1 drives dn.
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_UP   = 2'b01,
    PH_DN   = 2'b10,
    PH_BOTH = 2'b11
  } ph_state_e;

  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_SYN = 1;
  localparam int unsigned N_CH   = 2;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  localparam int unsigned SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], sig_i};
  end

  // Rising edge seen at the output of the last synchronising stage.
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
  import pfd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic syn_i,
  output logic up_o,
  output logic dn_o
);
  logic [N_CH-1:0] raw;
  logic [N_CH-1:0] rise;

  assign raw[CH_REF] = ref_i;
  assign raw[CH_SYN] = syn_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_sync
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_i (raw[g]),
      .rise_o(rise[g])
    );
  end

  ph_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PH_IDLE: begin
        unique case ({rise[CH_SYN], rise[CH_REF]})
          2'b01:   st_d = PH_UP;
          2'b10:   st_d = PH_DN;
          2'b11:   st_d = PH_BOTH;
          default: st_d = PH_IDLE;
        endcase
      end
      PH_UP:   if (rise[CH_SYN]) st_d = PH_BOTH;
      PH_DN:   if (rise[CH_REF]) st_d = PH_BOTH;
      PH_BOTH: st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PH_IDLE;
    else        st_q <= st_d;
  end

  assign up_o = st_q[0];
  assign dn_o = st_q[1];
endmodule

// File: rtl/pfd_width_meter.sv
module pfd_width_meter #(
  parameter int unsigned WID_W    = 8,
  parameter int unsigned LOCK_THR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  output logic done_o,
  output logic short_o
);
  localparam logic [WID_W-1:0] THR_V = WID_W'(LOCK_THR);
  localparam logic [WID_W-1:0] CNT_MAX = '1;

  logic             act;
  logic             act_q;
  logic [WID_W-1:0] cnt_q;

  assign act = up_i | dn_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cnt_q   <= '0;
      done_o  <= 1'b0;
      short_o <= 1'b0;
    end else begin
      act_q  <= act;
      done_o <= act_q & ~act;
      if (act) begin
        if (!act_q)               cnt_q <= WID_W'(1);
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (act_q && !act) short_o <= (cnt_q < THR_V);
    end
  end
endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl #(
  parameter int unsigned LOCK_CNT = 3,
  parameter int unsigned CODE_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              short_i,
  input  logic              ld_en,
  input  logic              sw_low,
  input  logic              div_wr,
  input  logic [CODE_W-1:0] code_hi,
  input  logic [CODE_W-1:0] code_lo,
  output logic [CODE_W-1:0] cur_code,
  output logic              hi_mode
);
  localparam int unsigned STK_W = $clog2(LOCK_CNT + 1);
  localparam logic [STK_W-1:0] STK_TOP  = STK_W'(LOCK_CNT);
  localparam logic [STK_W-1:0] STK_LAST = STK_W'(LOCK_CNT - 1);

  logic [STK_W-1:0] streak_q;
  logic             lock_low_q;
  logic             short_ep;

  assign short_ep = done_i & short_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q   <= '0;
      lock_low_q <= 1'b0;
    end else if (div_wr || !ld_en) begin
      streak_q   <= '0;
      lock_low_q <= 1'b0;
    end else if (done_i) begin
      if (!short_i)                 streak_q <= '0;
      else if (streak_q != STK_TOP) streak_q <= streak_q + 1'b1;
      if (short_ep && streak_q >= STK_LAST) lock_low_q <= 1'b1;
    end
  end

  assign hi_mode  = ~(sw_low | lock_low_q);
  assign cur_code = hi_mode ? code_hi : code_lo;
endmodule

// File: rtl/pump_mode_pfd.sv
module pump_mode_pfd #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WID_W       = 8,
  parameter int unsigned LOCK_THR    = 4,
  parameter int unsigned LOCK_CNT    = 3,
  parameter int unsigned CODE_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fref,
  input  logic              fsyn,
  input  logic              ld_en,
  input  logic              sw_low,
  input  logic              div_wr,
  input  logic [CODE_W-1:0] code_hi,
  input  logic [CODE_W-1:0] code_lo,
  output logic              up,
  output logic              dn,
  output logic [CODE_W-1:0] cur_code,
  output logic              hi_mode,
  output logic              lpf_hc
);
  logic ep_done;
  logic ep_short;

  pfd_phase_core #(.SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .ref_i(fref),
    .syn_i(fsyn),
    .up_o (up),
    .dn_o (dn)
  );

  pfd_width_meter #(.WID_W(WID_W), .LOCK_THR(LOCK_THR)) u_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .up_i   (up),
    .dn_i   (dn),
    .done_o (ep_done),
    .short_o(ep_short)
  );

  pfd_lock_ctrl #(.LOCK_CNT(LOCK_CNT), .CODE_W(CODE_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .done_i  (ep_done),
    .short_i (ep_short),
    .ld_en   (ld_en),
    .sw_low  (sw_low),
    .div_wr  (div_wr),
    .code_hi (code_hi),
    .code_lo (code_lo),
    .cur_code(cur_code),
    .hi_mode (hi_mode)
  );

  assign lpf_hc = hi_mode;
endmodule

// File: rtl/pump_mode_pfd_chk.sv
module pump_mode_pfd_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_en,
  input logic sw_low,
  input logic div_wr,
  input logic up,
  input logic dn,
  input logic hi_mode
);
  // R5
  both_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |=> (!up && !dn));

  // R7
  sw_low_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_low |-> !hi_mode);

  // R11
  div_wr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (hi_mode || sw_low));

  // R10
  no_auto_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !$past(ld_en) && !sw_low) |-> hi_mode);

  // R8
  lock_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hi_mode) && !sw_low) |-> $past(ld_en));
endmodule

bind pump_mode_pfd pump_mode_pfd_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ld_en  (ld_en),
  .sw_low (sw_low),
  .div_wr (div_wr),
  .up     (up),
  .dn     (dn),
  .hi_mode(hi_mode)
);

// File: tb/pump_mode_pfd_test.sv
module pump_mode_pfd_test;
  localparam int CLK_P = 10;
  localparam logic [5:0] CH = 6'h2A;
  localparam logic [5:0] CL = 6'h05;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fref = 1'b0, fsyn = 1'b0;
  logic ld_en = 1'b0, sw_low = 1'b0, div_wr = 1'b0;
  logic up, dn, hi_mode, lpf_hc;
  logic [5:0] cur_code;

  int n_chk = 0, n_fail = 0;
  int qu[$], qd[$];
  string qt[$];
  int uc = 0, dc = 0;
  bit active = 0;

  pump_mode_pfd uut (
    .clk(clk), .rst_n(rst_n), .fref(fref), .fsyn(fsyn),
    .ld_en(ld_en), .sw_low(sw_low), .div_wr(div_wr),
    .code_hi(CH), .code_lo(CL),
    .up(up), .dn(dn), .cur_code(cur_code), .hi_mode(hi_mode), .lpf_hc(lpf_hc)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: measure each error episode and compare with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (up || dn) begin
        active = 1;
        uc += int'(up);
        dc += int'(dn);
      end else if (active) begin
        active = 0;
        if (qu.size() == 0) begin
          chk(0, "R2 unexpected episode", uc, -1);
        end else begin
          int eu, ed;
          string t;
          eu = qu.pop_front();
          ed = qd.pop_front();
          t  = qt.pop_front();
          chk(uc == eu, {t, " up width"}, uc, eu);
          chk(dc == ed, {t, " dn width"}, dc, ed);
        end
        uc = 0;
        dc = 0;
      end
    end
  end

  // Driver: one error episode with the leader ahead by d cycles.
  task automatic pulse(input bit ref_first, input int d, input string tag);
    if (d == 0) begin qu.push_back(1); qd.push_back(1); end
    else if (ref_first) begin qu.push_back(d + 1); qd.push_back(1); end
    else begin qu.push_back(1); qd.push_back(d + 1); end
    qt.push_back(tag);
    @(negedge clk);
    if (d == 0) begin fref = 1'b1; fsyn = 1'b1; end
    else if (ref_first) fref = 1'b1;
    else fsyn = 1'b1;
    repeat (d) @(negedge clk);
    fref = 1'b1;
    fsyn = 1'b1;
    repeat (d + 6) @(negedge clk);
    fref = 1'b0;
    fsyn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic mode_chk(input bit exp_hi, input string tag);
    chk(hi_mode == exp_hi, {tag, " hi_mode"}, int'(hi_mode), int'(exp_hi));
    chk(lpf_hc == exp_hi, {"R12 lpf_hc ", tag}, int'(lpf_hc), int'(exp_hi));
    chk(cur_code == (exp_hi ? CH : CL), {"R6 cur_code ", tag}, int'(cur_code),
        int'(exp_hi ? CH : CL));
  endtask

  task automatic strobe_div();
    @(negedge clk);
    div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(up == 1'b0, "R1 up", int'(up), 0);
    chk(dn == 1'b0, "R1 dn", int'(dn), 0);
    mode_chk(1'b1, "R1");

    // Polarity and width, auto lock disabled (R2, R3, R4, R5)
    pulse(1'b1, 3, "R2 R5");
    pulse(1'b0, 3, "R3 R5");
    pulse(1'b1, 0, "R4");
    pulse(1'b1, 1, "R2");
    pulse(1'b0, 5, "R3");

    // R10: short episodes with ld_en low do not lock
    repeat (3) pulse(1'b1, 1, "R10");
    mode_chk(1'b1, "R10");

    // R8: lock after three short episodes
    ld_en = 1'b1;
    @(negedge clk);
    pulse(1'b1, 1, "R8");
    pulse(1'b0, 1, "R8");
    mode_chk(1'b1, "R8 before lock");
    pulse(1'b1, 2, "R8");
    mode_chk(1'b0, "R8 locked");

    // R11: long episode keeps low mode, divider write restores high
    pulse(1'b1, 6, "R11");
    mode_chk(1'b0, "R11 held low");
    strobe_div();
    mode_chk(1'b1, "R11 after write");

    // R9: long episode breaks the run
    pulse(1'b1, 1, "R9");
    pulse(1'b1, 1, "R9");
    pulse(1'b0, 4, "R9");
    pulse(1'b1, 1, "R9");
    pulse(1'b0, 1, "R9");
    mode_chk(1'b1, "R9 run broken");
    pulse(1'b1, 1, "R9");
    mode_chk(1'b0, "R9 relocked");

    // R8 boundary: width equal to threshold is not short
    strobe_div();
    repeat (3) pulse(1'b1, 3, "R8 boundary");
    mode_chk(1'b1, "R8 width at threshold");
    repeat (3) pulse(1'b0, 2, "R8 boundary");
    mode_chk(1'b0, "R8 width below threshold");

    // R10: clearing ld_en returns to high current
    @(negedge clk);
    ld_en = 1'b0;
    repeat (2) @(negedge clk);
    mode_chk(1'b1, "R10 disable");

    // R7: software request
    sw_low = 1'b1;
    @(negedge clk);
    mode_chk(1'b0, "R7 request");
    sw_low = 1'b0;
    @(negedge clk);
    mode_chk(1'b1, "R7 release");

    // R11: divider write in mid-run restarts the count
    ld_en = 1'b1;
    @(negedge clk);
    pulse(1'b1, 1, "R11");
    pulse(1'b1, 1, "R11");
    strobe_div();
    pulse(1'b1, 1, "R11");
    mode_chk(1'b1, "R11 run restarted");
    pulse(1'b1, 1, "R11");
    pulse(1'b1, 1, "R11");
    mode_chk(1'b0, "R11 relocked");

    repeat (4) @(negedge clk);
    chk(qu.size() == 0, "R2 scoreboard drained", qu.size(), 0);
    summary();
  end
endmodule